// File: doc/BRIEF.md
# Float-to-Signed-Integer Converter with Saturation

This block turns an already unpacked floating-point operand into a signed two's-complement integer. It always truncates toward zero. The operand arrives as four fields: a class code, a sign bit, an unbiased signed exponent and a normalized mantissa. The mantissa's leading one sits at its top bit, so the operand's value is `mant * 2^(exp - (MANT_W-1))`. The block is purely combinational. It is meant to sit in the result path of a floating-point conversion unit, feeding the integer write-back and the exception accumulation logic.

The mantissa is moved into integer position by a right shift. The shift distance follows from the exponent and is capped at the mantissa width. Every bit that falls off the low end is folded into a sticky bit, and that bit drives a loss (inexact) flag. Out-of-range values, infinities and NaNs are clamped to a limit that depends on the sign, and they raise an invalid-conversion flag. The positive and negative limits differ by one. The most negative integer is therefore reached exactly and is not treated as an overflow. The integer width `INT_W` is 32 or 64.

Top module: `fp_to_int`

## Requirements
- R1: Class code 0 (zero) gives result 0 with both flags low, whatever the other fields hold.
- R2: Class code 1 (number) with exponent at or above `INT_W` gives the saturated result (0x7FF..F when sign is 0, 0x800..0 when sign is 1), raises invalid and leaves loss low.
- R3: For class 1 with exponent below `INT_W`, the magnitude is `floor(mant / 2^(MANT_W-1-exp))`. The result is never rounded up, and a positive in-range result equals the magnitude.
- R4: When `MANT_W-1-exp` is `MANT_W` or more, including any very negative exponent, the magnitude is 0, the result is 0, invalid stays low and loss equals the OR of all mantissa bits.
- R5: For class 1 with exponent below `INT_W`, loss is high exactly when a nonzero bit was discarded by the shift. This also holds when the value then overflows, in which case loss and invalid are both high.
- R6: With sign 1, an in-range result is the two's-complement negation of the magnitude. A magnitude of exactly `2^(INT_W-1)` gives 0x800..0 with invalid low.
- R7: A magnitude of `2^(INT_W-1)` or more with sign 0, or more than `2^(INT_W-1)` with sign 1, saturates as in R2 and raises invalid.
- R8: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN) saturate by sign as in R2, with invalid high and loss low. The unused codes 5 to 7 behave the same way.
- R9: With `INT_W` = 64, the same rules hold at the 64-bit limits (0x7FFF_FFFF_FFFF_FFFF and 0x8000_0000_0000_0000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_i | input | 3 | Operand class: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | EXP_W | Unbiased exponent, two's complement |
| mant_i | input | MANT_W | Normalized mantissa, leading one at bit MANT_W-1 |
| result_o | output | INT_W | Signed integer result |
| inexact_o | output | 1 | Nonzero bits were lost in the shift |
| invalid_o | output | 1 | Conversion out of range or operand not a number |

## Verification
The bench aims at the sign-dependent edge. Positive `2^(W-1)` must saturate while negative `2^(W-1)` must convert exactly, so a design using one symmetric threshold fails one of the two. It probes negative `2^(W-1)` carrying a lost fraction, where a design that clears loss, or that compares after negation, gives the wrong flags. It also probes `2^(W-1)+1` negative, where a missed saturation wraps the result to a positive number. Exponents far below zero and one past the integer width check the shift cap and the overflow cut: an uncapped shifter wraps and leaks mantissa bits into the result. Every special class code, including the unused ones, is checked to clamp without setting loss.

// File: rtl/fti_pkg.sv
package fti_pkg;

  localparam int unsigned FCLS_W = 3;

  // Operand class codes seen on cls_i.
  typedef enum logic [FCLS_W-1:0] {
    FCLS_ZERO = 3'd0,
    FCLS_NUM  = 3'd1,
    FCLS_INF  = 3'd2,
    FCLS_QNAN = 3'd3,
    FCLS_SNAN = 3'd4
  } fcls_e;

endpackage

// File: rtl/fti_shamt.sv
// Shift-distance generator: MANT_W-1-exp, clamped to [0, MANT_W],
// plus the exponent overflow cut (exp >= INT_W).
module fti_shamt #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16,
  localparam int SHW   = $clog2(MANT_W + 1)
) (
  input  logic [EXP_W-1:0] exp_i,
  output logic [SHW-1:0]   sh_o,
  output logic             big_o
);

  localparam int XW = EXP_W + 2;
  localparam logic signed [XW-1:0] TOP_POS = XW'(MANT_W - 1);
  localparam logic signed [XW-1:0] INT_LIM = XW'(INT_W);
  localparam logic signed [XW-1:0] SH_CAP  = XW'(MANT_W);
  localparam logic [SHW-1:0]       SH_MAX  = SHW'(MANT_W);

  logic signed [XW-1:0] exp_x;
  logic signed [XW-1:0] sh_full;

  always_comb begin
    exp_x   = {{2{exp_i[EXP_W-1]}}, exp_i};
    sh_full = TOP_POS - exp_x;
    big_o   = (exp_x >= INT_LIM);
    if (sh_full >= SH_CAP) begin
      sh_o = SH_MAX;
    end else if (sh_full < 0) begin
      sh_o = '0;
    end else begin
      sh_o = sh_full[SHW-1:0];
    end

    AST_SHAMT_RANGE: assert (sh_o <= SH_MAX); // R4
    AST_SHAMT_SMALL: assert (big_o || (exp_x > TOP_POS) || (sh_o != '0) || (exp_x == TOP_POS)); // R3
  end

endmodule

// File: rtl/fti_shift.sv
// Logarithmic right shifter that ORs every discarded bit into sticky.
module fti_shift #(
  parameter int MANT_W = 64,
  localparam int SHW   = $clog2(MANT_W + 1)
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic [SHW-1:0]    sh_i,
  output logic [MANT_W-1:0] mag_o,
  output logic              sticky_o
);

  localparam logic [SHW-1:0]    SH_MAX = SHW'(MANT_W);
  localparam logic [MANT_W-1:0] ONE    = {{(MANT_W-1){1'b0}}, 1'b1};

  logic [MANT_W-1:0] stg;
  logic [MANT_W-1:0] low_mask;
  logic              lost;

  always_comb begin
    stg  = mant_i;
    lost = 1'b0;
    for (int k = 0; k < SHW; k++) begin
      if ((1 << k) >= MANT_W) begin
        low_mask = '1;
      end else begin
        low_mask = (ONE << (1 << k)) - ONE;
      end
      if (sh_i[k]) begin
        lost = lost | (|(stg & low_mask));
        stg  = ((1 << k) >= MANT_W) ? '0 : (stg >> (1 << k));
      end
    end
    mag_o    = stg;
    sticky_o = lost;

    AST_SHIFT_NONE:  assert ((sh_i != '0) || ((mag_o == mant_i) && !sticky_o)); // R3
    AST_SHIFT_FLUSH: assert ((sh_i != SH_MAX) || ((mag_o == '0) && (sticky_o == |mant_i))); // R4
    AST_SHIFT_LEAD:  assert (!mant_i[MANT_W-1] || (sh_i >= SH_MAX) ||
                             mag_o[MANT_W-1-int'(sh_i)]); // R3
  end

endmodule

// File: rtl/fti_sat.sv
// Range check, sign application, saturation and flag generation.
module fti_sat
  import fti_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int MANT_W = 64
) (
  input  logic [FCLS_W-1:0] cls_i,
  input  logic              sign_i,
  input  logic              big_i,
  input  logic [MANT_W-1:0] mag_i,
  input  logic              sticky_i,
  output logic [INT_W-1:0]  result_o,
  output logic              inexact_o,
  output logic              invalid_o
);

  localparam int CW = MANT_W + 1;
  localparam logic [CW-1:0]    HALF_RANGE = CW'(1) << (INT_W - 1);
  localparam logic [INT_W-1:0] POS_LIM    = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] NEG_LIM    = {1'b1, {(INT_W-1){1'b0}}};

  logic             is_num;
  logic             is_zero;
  logic [CW-1:0]    bound;
  logic             range_over;
  logic [INT_W-1:0] mag_int;

  always_comb begin
    is_num     = (cls_i == FCLS_NUM);
    is_zero    = (cls_i == FCLS_ZERO);
    bound      = HALF_RANGE + CW'(sign_i);
    range_over = ({1'b0, mag_i} >= bound);
    mag_int    = mag_i[INT_W-1:0];

    invalid_o  = !is_zero && (!is_num || big_i || range_over);
    inexact_o  = is_num && !big_i && sticky_i;

    if (is_zero) begin
      result_o = '0;
    end else if (invalid_o) begin
      result_o = sign_i ? NEG_LIM : POS_LIM;
    end else if (sign_i) begin
      result_o = ~mag_int + 1'b1;
    end else begin
      result_o = mag_int;
    end

    AST_ZERO_QUIET:     assert (!is_zero || ((result_o == '0) && !inexact_o && !invalid_o)); // R1
    AST_SPECIAL_CLAMP:  assert (is_zero || is_num || (invalid_o && !inexact_o)); // R8
    AST_SIGN_AGREE:     assert (invalid_o || (result_o == '0) || (result_o[INT_W-1] == sign_i)); // R6
    AST_EXACT_MIN:      assert (!(is_num && !big_i && sign_i && ({1'b0, mag_i} == HALF_RANGE)) ||
                                (!invalid_o && (result_o == NEG_LIM))); // R6
    AST_NO_OVERFLOW:    assert (!(is_num && !sign_i && !invalid_o) || !result_o[INT_W-1]); // R7
  end

endmodule

// File: rtl/fp_to_int.sv
// Unpacked float -> signed integer, truncating toward zero, with saturation.
module fp_to_int
  import fti_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int MANT_W = 64,
  parameter int EXP_W  = 16
) (
  input  logic [2:0]        cls_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  output logic [INT_W-1:0]  result_o,
  output logic              inexact_o,
  output logic              invalid_o
);

  localparam int SHW = $clog2(MANT_W + 1);

  logic [SHW-1:0]    sh_amt;
  logic              exp_big;
  logic [MANT_W-1:0] mag;
  logic              sticky;

  fti_shamt #(
    .INT_W  (INT_W),
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
  ) u_shamt (
    .exp_i  (exp_i),
    .sh_o   (sh_amt),
    .big_o  (exp_big)
  );

  fti_shift #(
    .MANT_W   (MANT_W)
  ) u_shift (
    .mant_i   (mant_i),
    .sh_i     (sh_amt),
    .mag_o    (mag),
    .sticky_o (sticky)
  );

  fti_sat #(
    .INT_W     (INT_W),
    .MANT_W    (MANT_W)
  ) u_sat (
    .cls_i     (cls_i),
    .sign_i    (sign_i),
    .big_i     (exp_big),
    .mag_i     (mag),
    .sticky_i  (sticky),
    .result_o  (result_o),
    .inexact_o (inexact_o),
    .invalid_o (invalid_o)
  );

  always_comb begin
    AST_BIG_SATURATES: assert (!((cls_i == FCLS_NUM) && exp_big) || (invalid_o && !inexact_o)); // R2
  end

endmodule

// File: tb/fp_to_int_bench.sv
`timescale 1ns/1ps
module fp_to_int_bench;

  localparam int MANT_W = 64;
  localparam int EXP_W  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]        cls;
  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [MANT_W-1:0] mant;

  logic [31:0] r32;
  logic        ix32, iv32;
  logic [63:0] r64;
  logic        ix64, iv64;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  fp_to_int #(.INT_W(32), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_fp_to_int (
    .cls_i(cls), .sign_i(sign), .exp_i(expo), .mant_i(mant),
    .result_o(r32), .inexact_o(ix32), .invalid_o(iv32)
  );

  fp_to_int #(.INT_W(64), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_fp_to_int_w64 (
    .cls_i(cls), .sign_i(sign), .exp_i(expo), .mant_i(mant),
    .result_o(r64), .inexact_o(ix64), .invalid_o(iv64)
  );

  localparam logic [63:0] ONE_P0 = 64'h8000_0000_0000_0000;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] want);
    tests++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, want);
    end
  endtask

  task automatic drive(logic [2:0] c, logic s, int e, logic [63:0] m);
    @(negedge clk);
    cls  = c;
    sign = s;
    expo = EXP_W'(e);
    mant = m;
    #1;
  endtask

  task automatic want32(string tag, logic [31:0] r, logic ix, logic iv);
    chk({tag, " result32"},  64'(r32),  64'(r));
    chk({tag, " inexact32"}, 64'(ix32), 64'(ix));
    chk({tag, " invalid32"}, 64'(iv32), 64'(iv));
  endtask

  task automatic want64(string tag, logic [63:0] r, logic ix, logic iv);
    chk({tag, " result64"},  r64,       r);
    chk({tag, " inexact64"}, 64'(ix64), 64'(ix));
    chk({tag, " invalid64"}, 64'(iv64), 64'(iv));
  endtask

  task automatic t_zero_class();
    drive(3'd0, 1'b1, 200, 64'hDEAD_BEEF_0123_4567);
    want32("R1 zero class", 32'h0, 1'b0, 1'b0);
    want64("R1 zero class", 64'h0, 1'b0, 1'b0);
  endtask

  task automatic t_exact_and_fraction();
    drive(3'd1, 1'b0, 0, ONE_P0);
    want32("R3 one", 32'd1, 1'b0, 1'b0);
    drive(3'd1, 1'b0, 2, 64'hB800_0000_0000_0000);
    want32("R3 5.75 truncates", 32'd5, 1'b1, 1'b0);
    drive(3'd1, 1'b0, 30, '1);
    want32("R3 max positive", 32'h7FFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_negative();
    drive(3'd1, 1'b1, 2, 64'hB800_0000_0000_0000);
    want32("R6 -5.75", 32'hFFFF_FFFB, 1'b1, 1'b0);
    drive(3'd1, 1'b1, 0, ONE_P0);
    want32("R6 -1", 32'hFFFF_FFFF, 1'b0, 1'b0);
    want64("R9 -1", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    drive(3'd1, 1'b1, 31, ONE_P0);
    want32("R6 exact min", 32'h8000_0000, 1'b0, 1'b0);
    drive(3'd1, 1'b1, 31, 64'h8000_0000_8000_0000);
    want32("R6 min with fraction", 32'h8000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_tiny();
    drive(3'd1, 1'b0, -1, ONE_P0);
    want32("R4 half", 32'h0, 1'b1, 1'b0);
    drive(3'd1, 1'b1, -64, 64'h8000_0000_0000_0001);
    want32("R4 exp -64", 32'h0, 1'b1, 1'b0);
    drive(3'd1, 1'b0, -32768, ONE_P0);
    want32("R4 most negative exp", 32'h0, 1'b1, 1'b0);
    want64("R4 most negative exp", 64'h0, 1'b1, 1'b0);
    drive(3'd1, 1'b0, -300, 64'h0);
    want32("R4 empty mantissa", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_range_edges();
    drive(3'd1, 1'b0, 31, ONE_P0);
    want32("R7 +2^31", 32'h7FFF_FFFF, 1'b0, 1'b1);
    want64("R9 +2^31 fits", 64'h0000_0000_8000_0000, 1'b0, 1'b0);
    drive(3'd1, 1'b1, 31, 64'h8000_0001_0000_0000);
    want32("R7 -(2^31+1)", 32'h8000_0000, 1'b0, 1'b1);
    drive(3'd1, 1'b0, 31, 64'h8000_0000_8000_0000);
    want32("R5 loss with overflow", 32'h7FFF_FFFF, 1'b1, 1'b1);
    drive(3'd1, 1'b0, 32, ONE_P0);
    want32("R2 exp at width pos", 32'h7FFF_FFFF, 1'b0, 1'b1);
    drive(3'd1, 1'b1, 32, '1);
    want32("R2 exp at width neg", 32'h8000_0000, 1'b0, 1'b1);
    drive(3'd1, 1'b0, 32767, ONE_P0);
    want32("R2 huge exp", 32'h7FFF_FFFF, 1'b0, 1'b1);
  endtask

  task automatic t_specials();
    drive(3'd2, 1'b0, 0, 64'h0);
    want32("R8 +inf", 32'h7FFF_FFFF, 1'b0, 1'b1);
    drive(3'd2, 1'b1, 0, 64'h0);
    want32("R8 -inf", 32'h8000_0000, 1'b0, 1'b1);
    want64("R8 -inf", 64'h8000_0000_0000_0000, 1'b0, 1'b1);
    drive(3'd3, 1'b0, 0, 64'hC000_0000_0000_0001);
    want32("R8 qnan", 32'h7FFF_FFFF, 1'b0, 1'b1);
    drive(3'd4, 1'b1, -5, 64'hA000_0000_0000_0000);
    want32("R8 snan", 32'h8000_0000, 1'b0, 1'b1);
    drive(3'd7, 1'b0, 0, ONE_P0);
    want32("R8 unused code", 32'h7FFF_FFFF, 1'b0, 1'b1);
  endtask

  task automatic t_wide();
    drive(3'd1, 1'b1, 63, ONE_P0);
    want64("R9 exact min64", 64'h8000_0000_0000_0000, 1'b0, 1'b0);
    drive(3'd1, 1'b0, 63, ONE_P0);
    want64("R9 +2^63", 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    drive(3'd1, 1'b0, 62, '1);
    want64("R9 max64 with loss", 64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
    drive(3'd1, 1'b1, 64, ONE_P0);
    want64("R9 exp at width", 64'h8000_0000_0000_0000, 1'b0, 1'b1);
    drive(3'd1, 1'b1, 40, 64'hB800_0000_0000_0000);
    want64("R9 negative mid", 64'hFFFF_FE90_0000_0000, 1'b0, 1'b0);
  endtask

  initial begin
    cls  = 3'd0;
    sign = 1'b0;
    expo = '0;
    mant = '0;
    repeat (2) @(posedge clk);
    t_zero_class();
    t_exact_and_fraction();
    t_negative();
    t_tiny();
    t_range_edges();
    t_specials();
    t_wide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule